// File: doc/BRIEF.md
# Counterflow Result-Stationary FIR Array

This block is a finite impulse response filter built as a linear chain of `TAPS` processing elements. Each element holds one output sample in its accumulator while the work flows past it. Input samples enter at the high end of the chain and move down one element per clock. Coefficients enter at the low end and move up one element per clock. Both streams carry a bubble in every other slot, so each element does a multiply-accumulate only on alternate cycles. The array therefore accepts one sample every two clocks.

The block generates the coefficient stream itself. It walks a coefficient bank in descending tap order and tags the tap-zero entry. When that entry meets a sample, the element holding the output has seen its last product. The element then copies its result into a shift-out chain and clears its accumulator for its next output. Because every element sits at a different distance from the chain exit, results leave in increasing sample order, exactly two clocks apart.

Top module: `fir_counterflow_array`

## Requirements
- R1: While `rst` is high, and for the first `TAPS` rising edges after it falls, `out_valid` is low. Edges are counted from 0, starting with the first edge at which `rst` is low.
- R2: Each edge with `coef_valid` high shifts `coef_in` into the coefficient bank. After `TAPS` loads, the first value loaded is tap 0 and multiplies the newest sample, the second is tap 1, and so on.
- R3: Sample slot `m` is edge `2m`. In a slot, `in_data` is taken as x(m) when `in_valid` is high, and x(m) is zero when `in_valid` is low.
- R4: `in_valid` and `in_data` on odd edges have no effect on any output.
- R5: `out_y` is the exact signed sum over taps j of h(j)·x(m−j), with x of negative index equal to zero. It is `DW+CW+clog2(TAPS)` bits wide and never wraps.
- R6: Result y(m) is presented with `out_valid` high in the cycle after edge `2m+TAPS`. Outputs come in increasing m with none skipped, and `out_valid` alternates every cycle from then on.
- R7: A new coefficient set may be loaded once `TAPS` edges have passed since the last nonzero sample slot. It then applies exactly to every slot that is at least `TAPS` edges after the final load edge.
- R8: Full-scale inputs (the most negative data against the most negative coefficients on every tap, and the most positive data) give exact results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| coef_valid | input | 1 | Shift `coef_in` into the coefficient bank |
| coef_in | input | CW | Signed coefficient value |
| in_valid | input | 1 | Sample present in this slot |
| in_data | input | DW | Signed sample value |
| out_valid | output | 1 | `out_y` holds a finished result |
| out_y | output | DW+CW+clog2(TAPS) | Signed filter output |

## Verification
Suppose a sample tag or a weight tag is wrong, the tap pointer is misaligned, or an accumulator is not cleared. Then `out_y` is wrong for the affected outputs. The error shows at the port about `TAPS` cycles after the sample concerned. A missed capture, or a collision in the shift-out chain, breaks the strict alternation of `out_valid` or misplaces the first result. That is visible within one cycle of the fault reaching the chain exit. Random streams with empty slots and garbage on odd edges cover both kinds of fault, as do directed impulse, ramp and full-scale runs under three coefficient sets.

// File: rtl/fir_counterflow_array.sv
module fir_counterflow_array #(
  parameter int TAPS = 5,
  parameter int DW = 8,
  parameter int CW = 8,
  localparam int AW = DW + CW + $clog2(TAPS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 coef_valid,
  input  logic signed [CW-1:0] coef_in,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  output logic signed [AW-1:0] out_y
);
  localparam int PW = DW + CW;
  localparam int PTRW = $clog2(TAPS);
  localparam logic WPH = 1'((TAPS - 1) % 2);

  logic                 ph;
  logic [PTRW-1:0]      wptr;
  logic signed [CW-1:0] bank [TAPS];
  logic signed [DW-1:0] xr   [TAPS];
  logic                 xv   [TAPS];
  logic signed [CW-1:0] wr   [TAPS];
  logic                 wv   [TAPS];
  logic                 wz   [TAPS];
  logic signed [AW-1:0] acc  [TAPS];
  logic signed [AW-1:0] orr  [TAPS];
  logic                 ov   [TAPS];
  logic signed [PW-1:0] prod [TAPS];
  logic signed [AW-1:0] sum  [TAPS];
  logic                 hit  [TAPS];

  always_comb begin
    for (int p = 0; p < TAPS; p++) begin
      prod[p] = PW'(xr[p]) * PW'(wr[p]);
      sum[p]  = acc[p] + AW'(prod[p]);
      hit[p]  = xv[p] & wv[p];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph   <= 1'b0;
      wptr <= '0;
      for (int p = 0; p < TAPS; p++) begin
        bank[p] <= '0;
        xr[p] <= '0;  xv[p] <= 1'b0;
        wr[p] <= '0;  wv[p] <= 1'b0;  wz[p] <= 1'b0;
        acc[p] <= '0;
        orr[p] <= '0; ov[p] <= 1'b0;
      end
    end else begin
      ph <= ~ph;

      if (coef_valid) begin
        for (int k = 0; k < TAPS - 1; k++) bank[k] <= bank[k+1];
        bank[TAPS-1] <= coef_in;
      end

      xr[TAPS-1] <= (!ph && in_valid) ? in_data : '0;
      xv[TAPS-1] <= ~ph;
      for (int p = 0; p < TAPS - 1; p++) begin
        xr[p] <= xr[p+1];
        xv[p] <= xv[p+1];
      end

      wr[0] <= (ph == WPH) ? bank[wptr] : '0;
      wv[0] <= (ph == WPH);
      wz[0] <= (ph == WPH) && (wptr == '0);
      if (ph == WPH) wptr <= (wptr == '0) ? PTRW'(TAPS - 1) : wptr - PTRW'(1);
      for (int p = 1; p < TAPS; p++) begin
        wr[p] <= wr[p-1];
        wv[p] <= wv[p-1];
        wz[p] <= wz[p-1];
      end

      for (int p = 0; p < TAPS; p++)
        if (hit[p]) acc[p] <= wz[p] ? '0 : sum[p];

      for (int p = 0; p < TAPS - 1; p++) begin
        orr[p] <= (hit[p] && wz[p]) ? sum[p] : orr[p+1];
        ov[p]  <= (hit[p] && wz[p]) | ov[p+1];
      end
      orr[TAPS-1] <= (hit[TAPS-1] && wz[TAPS-1]) ? sum[TAPS-1] : '0;
      ov[TAPS-1]  <= hit[TAPS-1] && wz[TAPS-1];
    end
  end

  assign out_valid = ov[0];
  assign out_y     = orr[0];
endmodule

module fir_counterflow_array_chk #(
  parameter int TAPS = 5,
  parameter int YW = 19
) (
  input logic          clk,
  input logic          rst,
  input logic          out_valid,
  input logic [YW-1:0] out_y
);
  int cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= 0;
    else if (cnt < TAPS + 2) cnt <= cnt + 1;
  end

  p_quiet_start_r1: assert property (@(posedge clk) disable iff (rst)
    (cnt <= TAPS) |-> !out_valid);

  p_first_valid_r6: assert property (@(posedge clk) disable iff (rst)
    (cnt == TAPS + 1) |-> out_valid);

  p_alternate_r6: assert property (@(posedge clk) disable iff (rst)
    (cnt > TAPS) |-> (out_valid != $past(out_valid)));

  p_known_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !$isunknown(out_y));
endmodule

bind fir_counterflow_array fir_counterflow_array_chk #(.TAPS(TAPS), .YW(AW)) u_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_y(out_y)
);

// File: tb/sim_fir_counterflow_array.sv
module sim_fir_counterflow_array;
  localparam int N = 5;
  localparam int DW = 8;
  localparam int CW = 8;
  localparam int AW = DW + CW + $clog2(N);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic coef_valid = 1'b0;
  logic signed [CW-1:0] coef_in = '0;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] in_data = '0;
  logic out_valid;
  logic signed [AW-1:0] out_y;

  always #5 clk = ~clk;

  fir_counterflow_array #(.TAPS(N), .DW(DW), .CW(CW)) u0 (
    .clk(clk), .rst(rst), .coef_valid(coef_valid), .coef_in(coef_in),
    .in_valid(in_valid), .in_data(in_data), .out_valid(out_valid), .out_y(out_y)
  );

  int checks = 0, fails = 0, ecount = 0, cur_set = 0;
  bit done = 1'b0;
  int xs [0:2047];
  int sid [0:2047];
  int hs [0:2][0:N-1];
  int unsigned seed_ign;

  always @(posedge clk) if (!rst) ecount <= ecount + 1;

  function automatic longint yexp(int m);
    longint a = 0;
    for (int j = 0; j < N; j++)
      if (m - j >= 0) a += longint'(hs[sid[m]][j]) * longint'(xs[m-j]);
    return a;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive inputs for the coming edge; odd edges get garbage samples (R4)
  task automatic drive(bit cv, int cd, bit iv, int id);
    coef_valid = cv;
    coef_in = CW'(cd);
    if (ecount % 2 == 1) begin
      in_valid = 1'b1;
      in_data = DW'($urandom_range(255));
    end else begin
      in_valid = iv;
      in_data = DW'(id);
      xs[ecount/2] = iv ? id : 0;
      sid[ecount/2] = cur_set;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      drive(1'b0, 0, 1'b0, 0);
    end
  endtask

  task automatic slot(bit iv, int id);
    bit placed = 1'b0;
    while (!placed) begin
      @(negedge clk);
      placed = (ecount % 2 == 0);
      drive(1'b0, 0, iv, id);
    end
  endtask

  task automatic load_set(int s);
    cur_set = s;
    for (int j = 0; j < N; j++) begin
      @(negedge clk);
      drive(1'b1, hs[s][j], 1'b0, 0);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && ecount > 0 && !done) begin
      int k, m;
      bit ev;
      string tag;
      k = ecount - 1;
      ev = (k >= N) && ((k - N) % 2 == 0);
      chk(out_valid == ev, (k < N) ? "R1" : "R6", longint'(out_valid), longint'(ev));
      if (ev && out_valid) begin
        m = (k - N) / 2;
        tag = (sid[m] == 0) ? "R3 R4 R5" : (sid[m] == 1) ? "R2 R7" : "R8";
        chk(longint'(out_y) == yexp(m), tag, longint'(out_y), yexp(m));
      end
    end
  end

  initial begin
    for (int i = 0; i < 2048; i++) begin
      xs[i] = 0;
      sid[i] = 0;
    end
    seed_ign = $urandom(32'd20240611);
    for (int j = 0; j < N; j++) begin
      hs[0][j] = int'($urandom_range(255)) - 128;
      hs[1][j] = (j % 2 == 1) ? -(j + 1) : (j + 1);
      hs[2][j] = -128;
    end
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", longint'(out_valid), 0);
    @(negedge clk);
    rst = 1'b0;

    load_set(0);
    idle(2 * N);
    for (int i = 0; i < 160; i++) begin
      if (i % 37 == 5) slot(1'b1, -128);
      else if (i % 41 == 7) slot(1'b1, 127);
      else slot($urandom_range(9) != 0, int'($urandom_range(255)) - 128);
    end
    idle(2 * N);

    load_set(1);
    idle(2 * N);
    slot(1'b1, 1);
    for (int i = 0; i < N + 1; i++) slot(1'b0, 0);
    for (int i = 0; i < 12; i++) slot(1'b1, i - 6);
    idle(2 * N);

    load_set(2);
    idle(2 * N);
    for (int i = 0; i < N + 3; i++) slot(1'b1, -128);
    for (int i = 0; i < N + 3; i++) slot(1'b1, 127);
    idle(2 * N + 4);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R6 actual=%0d expected=%0d", ecount, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule